// File: doc/BRIEF.md
# Serial Two-Wire EEPROM Slave

This block models a 256-word by 8-bit nonvolatile memory behind a two-wire I2C slave port. It samples the serial clock and data lines with the system clock and finds start and stop conditions. It shifts whole bytes in and out, and it acknowledges each byte by pulling the data line low. The data line is open drain. The block only pulls it low through an output enable, and it never drives it high.

A write transaction has three bytes: a device address byte with the write flag, a word address, and one data byte. A stop then launches a self-timed programming cycle of a parameterised number of system clock cycles. While that cycle runs, the slave ignores its own address. A master finds out that programming is over by sending a start and the device address again and again until an acknowledge comes back. A read can follow a dummy write that sets the word address, joined to it by a repeated start. The read then streams bytes from consecutive addresses for as long as the master acknowledges them.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the slave releases the data line (`sda_oe` = 0) and `busy` is 0.
- R2: The device address byte is, MSB first, 1010, then `sel_i[2:0]`, then the R/W bit (0 = write, 1 = read). The slave does not acknowledge a byte whose upper seven bits differ from this pattern. It then stays silent for the rest of that transaction, and a following stop starts no programming.
- R3: A matching write address byte, a word address byte and a first data byte are each acknowledged: the slave holds SDA low through the 9th SCL pulse. A stop after that data byte raises `busy`.
- R4: `busy` stays high for exactly WRITE_CYCLES system clock cycles. While it is high, the device address is not acknowledged, so an address poll returns no acknowledge until the cycle has ended.
- R5: After the programming cycle, a read of that word address returns the written byte.
- R6: During a read, the word address increments after each byte sent and wraps from 255 to 0.
- R7: When transmitting, the slave releases SDA during the 9th pulse. After a master non-acknowledge it drives nothing more until the next start.
- R8: A stop that arrives before a complete data byte has been received leaves `busy` at 0 and the memory unchanged.
- R9: A repeated start in mid-transaction returns the slave to expecting a device address byte. This allows a word address write to be followed directly by a read.
- R10: Only the first data byte of a write transaction is accepted. Later data bytes are not acknowledged and change no memory word.
- R11: The slave changes its SDA output only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND of all drivers) |
| sel_i | input | 3 | Device select bits compared against address bits 3..1 |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| busy | output | 1 | High while the internal programming cycle runs |

## Verification
Both bus lines pass through a two-flop synchroniser and an edge register, so the slave reacts to an SCL edge about three system clocks after the bench moves SCL. The bench therefore holds each SCL phase for four clocks. It changes SDA one clock into the low phase and samples the wired line two clocks into the high phase, when any acknowledge or data bit from the slave has settled. `busy` rises about three clocks after the stop edge, so it is checked at the end of the stop sequence, four clocks after SDA rises. Its high time is measured edge to edge by a monitor and compared against WRITE_CYCLES exactly.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int          WRITE_CYCLES = 500000,
  parameter logic [3:0]  DEV_CODE     = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  output logic       sda_oe,
  output logic       busy
);
  localparam int TW = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {P_IDLE, P_DEV, P_WADDR, P_WDATA, P_READ} phase_t;

  logic [7:0]    mem [256];
  logic [2:0]    scl_q, sda_q;
  phase_t        phase;
  logic [3:0]    cnt;
  logic [7:0]    shreg, tx, addr, waddr, wdata;
  logic          have, rack;
  logic [TW-1:0] timer;

  wire scl_s     = scl_q[1];
  wire sda_s     = sda_q[1];
  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_c   = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_c    = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire prog_done = busy && (timer == '0);
  wire dev_hit   = (shreg[7:1] == {DEV_CODE, sel_i}) && !busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  always_ff @(posedge clk)
    if (prog_done) mem[waddr] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase  <= P_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      tx     <= '0;
      addr   <= '0;
      waddr  <= '0;
      wdata  <= '0;
      have   <= 1'b0;
      rack   <= 1'b1;
      sda_oe <= 1'b0;
      busy   <= 1'b0;
      timer  <= '0;
    end else begin
      if (busy) begin
        if (timer == '0) busy <= 1'b0;
        else             timer <= timer - 1'b1;
      end
      if (start_c) begin
        phase <= P_DEV;
        cnt   <= '0;
        have  <= 1'b0;
      end else if (stop_c) begin
        if (phase == P_WDATA && have) begin
          busy  <= 1'b1;
          timer <= TW'(WRITE_CYCLES - 1);
        end
        phase <= P_IDLE;
        have  <= 1'b0;
      end else if (scl_rise) begin
        if (cnt < 4'd8)  shreg <= {shreg[6:0], sda_s};
        if (cnt == 4'd8) rack <= sda_s;
        if (cnt != 4'd9) cnt <= cnt + 1'b1;
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          case (phase)
            P_DEV: begin
              if (dev_hit) begin
                sda_oe <= 1'b1;
                phase  <= shreg[0] ? P_READ : P_WADDR;
              end else phase <= P_IDLE;
            end
            P_WADDR: begin
              addr   <= shreg;
              sda_oe <= 1'b1;
              phase  <= P_WDATA;
            end
            P_WDATA: if (!have) begin
              wdata  <= shreg;
              waddr  <= addr;
              have   <= 1'b1;
              sda_oe <= 1'b1;
            end
            P_READ:  sda_oe <= 1'b0;
            default: ;
          endcase
        end else if (cnt == 4'd9) begin
          cnt    <= '0;
          sda_oe <= 1'b0;
          if (phase == P_READ) begin
            if (!rack) begin
              tx     <= mem[addr];
              sda_oe <= ~mem[addr][7];
              addr   <= addr + 1'b1;
            end else phase <= P_IDLE;
          end
        end else if (phase == P_READ && cnt != 4'd0) begin
          sda_oe <= ~tx[3'(4'd7 - cnt)];
        end
      end
    end

  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !sda_oe); // R4
  AST_BUSY_HOLDS:       assert property (@(posedge clk) disable iff (!rst_n) (busy && timer != '0) |=> busy); // R4
  AST_PROG_NEEDS_DATA:  assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(have)); // R8
  AST_SDA_ON_LOW:       assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !$past(scl_s)); // R11
  AST_NO_DRIVE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> $past(phase) != P_IDLE); // R2
endmodule

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int WC = 120;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
  logic sda_oe, busy;
  wire  sda_bus = msda & ~sda_oe;
  int   n_chk = 0, n_fail = 0, run = 0, last_run = 0;

  always #10 clk = ~clk;

  i2c_eeprom_slave #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sel_i(SEL), .sda_oe(sda_oe), .busy(busy));

  always @(negedge clk)
    if (busy) run <= run + 1;
    else if (run != 0) begin last_run <= run; run <= 0; end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic w(input int k); repeat (k) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic r);
    scl = 1'b0; w(1); msda = b; w(3); scl = 1'b1; w(2); r = sda_bus; w(2);
  endtask

  task automatic do_start();
    scl = 1'b0; w(1); msda = 1'b1; w(3); scl = 1'b1; w(4); msda = 1'b0; w(4);
  endtask

  task automatic do_stop();
    scl = 1'b0; w(1); msda = 1'b0; w(3); scl = 1'b1; w(4); msda = 1'b1; w(4);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d, output logic oe9);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, r); d = {d[6:0], r}; end
    scl = 1'b0; w(1); msda = !mack; w(3); scl = 1'b1; w(2); oe9 = sda_oe; w(2);
  endtask

  task automatic poll(output int p);
    logic a;
    p = 0;
    do begin do_start(); send_byte(DEV_W, a); do_stop(); p++; end while (!a);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    w(190000);
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic a1, a2, a3, oe9, r;
    logic [7:0] d;
    int p;
    w(5);
    chk("R1 oe", sda_oe, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1'b1; w(3);
    chk("R1 oe after release", sda_oe, 0);

    // R2: wrong select bits
    do_start();
    send_byte({4'b1010, 3'b010, 1'b0}, a1);
    chk("R2 foreign address nack", a1, 0);
    send_byte(8'h33, a2);
    chk("R2 later byte ignored", a2, 0);
    do_stop();
    chk("R2 no programming", busy, 0);

    // R3/R4 exhaustive write sweep
    for (int a = 0; a < 256; a++) begin
      do_start();
      send_byte(DEV_W, a1); send_byte(8'(a), a2); send_byte(pat(a), a3);
      do_stop();
      chk("R3 acks", {a1, a2, a3}, 3'b111);
      chk("R3 busy after stop", busy, 1);
      poll(p);
      if (a == 0) begin
        chk("R4 first poll nacked", p, 2);
        chk("R4 busy length", last_run, WC);
      end
    end

    // R10: second data byte refused
    do_start();
    send_byte(DEV_W, a1); send_byte(8'd7, a2); send_byte(8'h5A, a3);
    chk("R10 first data ack", a3, 1);
    send_byte(8'hC3, a3);
    chk("R10 second data nack", a3, 0);
    do_stop();
    poll(p);

    // R8: stop without data
    do_start();
    send_byte(DEV_W, a1); send_byte(8'd9, a2);
    do_stop(); w(5);
    chk("R8 no busy", busy, 0);

    // R9 random read of whole array with wrap (R6), R5 data
    do_start();
    send_byte(DEV_W, a1); send_byte(8'd0, a2);
    do_start();
    send_byte(DEV_R, a3);
    chk("R9 read address ack after repeated start", a3, 1);
    for (int i = 0; i < 258; i++) begin
      logic [7:0] e;
      int ad;
      ad = i & 255;
      e = (ad == 7) ? 8'h5A : pat(ad);
      recv_byte(i != 257, d, oe9);
      if (i >= 256)     chk("R6 wrap data", d, e);
      else if (ad == 7 || ad == 8) chk("R10 data", d, e);
      else if (ad == 9) chk("R8 data unchanged", d, e);
      else              chk("R5 data", d, e);
      chk("R7 released in ack slot", oe9, 0);
    end
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, r);
      chk("R7 silent after nack", r, 1);
    end
    do_stop();

    // R6: wrap from 254
    do_start();
    send_byte(DEV_W, a1); send_byte(8'd254, a2);
    do_start();
    send_byte(DEV_R, a3);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, d, oe9);
      chk("R6 wrap read", d, pat((254 + i) & 255));
    end
    do_stop();
    w(4);
    chk("R11 bus idle released", sda_oe, 0);
    finish_run();
  end
endmodule